// File: doc/BRIEF.md
# I2C Slave Receive Buffer with Clock Stretching

This block is the receive half of an I2C target. It watches a bus clock and data line that are already synchronised to the system clock. Each bit is taken on a rising bus-clock edge, most significant bit first. When the eighth bit arrives, the completed byte is copied into a holding register, a ready flag is raised and an interrupt pulse is issued. In the ninth clock the block pulls the data line low as an acknowledge, but only for bytes it has accepted.

Software, or a later stage, takes the byte with a read strobe, and the read lowers the ready flag. If the ready flag is still up while a further accepted byte is coming in, the block pulls the bus clock low in the low phase before that byte's final bit. It keeps the clock low until the flag drops, so a waiting byte is never overwritten. An external decoder supplies the address-phase and address-match indications, plus a combined pulse for START and STOP conditions. An interactive mode makes every byte reportable, address bytes included.

Top module: `i2cSlaveRxBuf`

## Requirements
- R1: Bits are shifted in MSB first on each rising edge of `sclIn`. On the eighth rising edge of a byte, an accepted byte is written to `rxData`. `rxData` changes at no other time.
- R2: `rxFull` goes high in the cycle after an accepted byte is written to `rxData`.
- R3: A one-cycle `dataRd` pulse lowers `rxFull` in the next cycle and leaves `rxData` unchanged. A read while `rxFull` is low has no effect.
- R4: Suppose `rxFull` is high, seven bits of a further accepted byte have been taken, and `sclIn` is low. Then `sclHold` is driven high and stays high until `rxFull` falls. `sclHold` drops one clock after `rxFull` falls. The held byte is never overwritten.
- R5: With `irmEn` low, a byte completed while `addrPhase` is high is not accepted. That byte causes no write, no `rxFull` and no `rxIrq`.
- R6: With `irmEn` low, a data byte (`addrPhase` low) completed while `addrMatch` is low is not accepted.
- R7: With `irmEn` high, every byte is accepted, whatever `addrPhase` and `addrMatch` are.
- R8: For an accepted byte, `sdaAck` is high from the `sclIn` fall after the eighth rise until the `sclIn` fall after the ninth rise. For a byte that is not accepted, `sdaAck` stays low.
- R9: A `startStop` pulse sets the bit count back to zero and drops `sclHold` and `sdaAck` in the next cycle. It leaves `rxFull` and `rxData` unchanged.
- R10: `rxIrq` is a single-cycle pulse, issued once for each accepted byte, at the same time as `rxFull` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level |
| startStop | input | 1 | One-cycle pulse when a START or STOP condition is detected |
| addrPhase | input | 1 | High while the current byte is an address byte |
| addrMatch | input | 1 | High when the current transaction addressed this target |
| irmEn | input | 1 | Interactive mode: accept and report every byte |
| dataRd | input | 1 | Read strobe for the data register |
| rxData | output | 8 | Last accepted byte |
| rxFull | output | 1 | Data register holds an unread byte |
| rxIrq | output | 1 | One-cycle receive interrupt pulse |
| sclHold | output | 1 | Pull bus clock low when high |
| sdaAck | output | 1 | Pull bus data low (acknowledge) when high |

## Verification
The hardest state to reach is a stretch in progress. This needs an unread byte in the register together with a second accepted byte that has stopped just before its last bit. The bench builds it with a bus master model that honours clock stretching, since it sees the clock as the AND of its own drive and the inverse of `sclHold`. The model runs alongside a thread that waits for the hold and then reads. A second path leaves a byte stretched and ends the stretch with a START/STOP pulse, to show the hold drops while the held byte survives.

// File: rtl/i2cRxPkg.sv
package i2cRxPkg;
  typedef struct packed {
    logic shiftEn;   // take sdaIn into the shift register
    logic loadEn;    // move completed byte to the data register
    logic clrShift;  // bus condition: discard partial byte
  } rxStrobe_t;
endpackage

// File: rtl/i2cRxCtrl.sv
module i2cRxCtrl
  import i2cRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       startStop,
  input  logic       addrPhase,
  input  logic       addrMatch,
  input  logic       irmEn,
  input  logic       dataRd,
  output rxStrobe_t  strb,
  output logic       rxFull,
  output logic       rxIrq,
  output logic       sclHold,
  output logic       sdaAck
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(DATA_W);

  logic             sclPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             ackPend;
  logic             sclRise, sclFall, lastBit, ackSlot, takeByte;

  assign sclRise  = sclIn & ~sclPrev;
  assign sclFall  = ~sclIn & sclPrev;
  assign lastBit  = (bitCnt == LAST_CNT);
  assign ackSlot  = (bitCnt == ACK_CNT);
  assign takeByte = irmEn | (~addrPhase & addrMatch);

  always_comb begin
    strb.shiftEn  = sclRise & ~ackSlot;
    strb.loadEn   = sclRise & lastBit & takeByte;
    strb.clrShift = startStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      bitCnt  <= '0;
    end else begin
      sclPrev <= sclIn;
      if (startStop)   bitCnt <= '0;
      else if (sclRise) bitCnt <= ackSlot ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end else begin
      rxIrq <= strb.loadEn;
      if (strb.loadEn) rxFull <= 1'b1;
      else if (dataRd) rxFull <= 1'b0;
    end
  end

  // Stretch in the low phase ahead of the last bit of a byte that would load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclHold <= 1'b0;
    else       sclHold <= ~startStop & lastBit & rxFull & takeByte & ~sclIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPend <= 1'b0;
      sdaAck  <= 1'b0;
    end else begin
      if (sclRise && lastBit) ackPend <= takeByte;
      if (startStop)                        sdaAck <= 1'b0;
      else if (sclFall && ackSlot)          sdaAck <= ackPend;
      else if (sclFall && bitCnt == '0)     sdaAck <= 1'b0;
    end
  end

  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |-> !rxFull);
  a_r2_full_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> rxFull);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strb.loadEn) |=> !rxFull);
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |=> !sclHold);
  a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  a_r8_ack_window: assert property (@(posedge clk) disable iff (!rstN)
    sdaAck |-> (ackSlot || bitCnt == '0));
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    startStop |=> (bitCnt == '0 && !sclHold && !sdaAck));
endmodule

// File: rtl/i2cRxDatapath.sv
module i2cRxDatapath
  import i2cRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaIn,
  input  rxStrobe_t         strb,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
    end else begin
      if (strb.clrShift)     shiftReg <= '0;
      else if (strb.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (strb.loadEn)       rxData   <= {shiftReg[DATA_W-2:0], sdaIn};
    end
  end

  a_r1_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadEn |=> $stable(rxData));
endmodule

// File: rtl/i2cSlaveRxBuf.sv
module i2cSlaveRxBuf
  import i2cRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              startStop,
  input  logic              addrPhase,
  input  logic              addrMatch,
  input  logic              irmEn,
  input  logic              dataRd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxIrq,
  output logic              sclHold,
  output logic              sdaAck
);
  rxStrobe_t strb;

  i2cRxCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .startStop(startStop),
    .addrPhase(addrPhase), .addrMatch(addrMatch), .irmEn(irmEn),
    .dataRd(dataRd), .strb(strb), .rxFull(rxFull), .rxIrq(rxIrq),
    .sclHold(sclHold), .sdaAck(sdaAck)
  );

  i2cRxDatapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .strb(strb), .rxData(rxData)
  );
endmodule

// File: tb/i2cSlaveRxBuf_test.sv
`timescale 1ns/1ps
module i2cSlaveRxBuf_test;
  localparam int HALF = 16;
  // vector: [11:4] byte, [3] addrPhase, [2] addrMatch, [1] irmEn, [0] expected accept
  localparam logic [11:0] VECS [0:7] = '{
    {8'hA5, 4'b1000}, {8'h3C, 4'b0101}, {8'h81, 4'b0000}, {8'h7E, 4'b1111},
    {8'h00, 4'b0011}, {8'hFF, 4'b0101}, {8'h5A, 4'b1100}, {8'hC3, 4'b0011}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic startStop = 1'b0, addrPhase = 1'b0, addrMatch = 1'b0, irmEn = 1'b0, dataRd = 1'b0;
  logic [7:0] rxData;
  logic rxFull, rxIrq, sclHold, sdaAck;
  logic sclBus, sdaBus, lastSample;
  int checks = 0, failures = 0, irqCnt = 0;
  bit done = 1'b0;

  assign sclBus = sclM & ~sclHold;
  assign sdaBus = sdaM & ~sdaAck;

  always #5 clk = ~clk;

  i2cSlaveRxBuf uut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .startStop(startStop),
    .addrPhase(addrPhase), .addrMatch(addrMatch), .irmEn(irmEn), .dataRd(dataRd),
    .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq), .sclHold(sclHold), .sdaAck(sdaAck)
  );

  always @(negedge clk) if (rxIrq) irqCnt <= irqCnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clkBit(input logic b);
    @(negedge clk) sdaM = b;
    repeat (HALF) @(negedge clk);
    sclM = 1'b1;
    while (!sclBus) @(negedge clk);
    repeat (HALF) @(negedge clk);
    lastSample = sdaBus;
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) clkBit(b[i]);
    clkBit(1'b1);
    acked = ~lastSample;
    repeat (4) @(negedge clk);
  endtask

  task automatic readData();
    @(negedge clk) dataRd = 1'b1;
    @(negedge clk) dataRd = 1'b0;
  endtask

  task automatic pulseStartStop();
    @(negedge clk) startStop = 1'b1;
    @(negedge clk) startStop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] prev;
    int irq0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rxFull == 0, "R2 reset rxFull", rxFull, 0);
    check(sclHold == 0 && sdaAck == 0, "R4 reset drives", {sclHold, sdaAck}, 0);
    check(rxData == 0 && rxIrq == 0, "R1 reset data", rxData, 0);
    sclM = 1'b0;

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [7:0] val;
      logic take;
      string tag;
      val = VECS[v][11:4];
      addrPhase = VECS[v][3]; addrMatch = VECS[v][2]; irmEn = VECS[v][1];
      take = VECS[v][0];
      tag = irmEn ? "R7" : (addrPhase ? "R5" : (!addrMatch ? "R6" : "R1"));
      prev = rxData;
      irq0 = irqCnt;
      sendByte(val, ack);
      check(rxData == (take ? val : prev), {tag, " data"}, rxData, take ? val : prev);
      check(rxFull == take, {tag, " R2 full"}, rxFull, take);
      check(ack == take, {tag, " R8 ack"}, ack, take);
      check(irqCnt - irq0 == int'(take), {tag, " R10 irq"}, irqCnt - irq0, take);
      if (rxFull) begin
        prev = rxData;
        readData();
        check(rxFull == 0 && rxData == prev, "R3 read clears", rxFull, 0);
      end
    end

    // R3: read while empty does nothing
    prev = rxData;
    readData();
    check(rxFull == 0 && rxData == prev, "R3 empty read", rxData, prev);

    // R4: stretch until read, release one clock after clear
    addrPhase = 1'b0; addrMatch = 1'b1; irmEn = 1'b0;
    sendByte(8'h11, ack);
    check(rxFull == 1 && rxData == 8'h11, "R4 first byte", rxData, 8'h11);
    fork
      sendByte(8'h96, ack);
      begin
        int n = 0;
        while (!sclHold && n < 400) begin @(negedge clk); n++; end
        check(sclHold == 1, "R4 hold asserted", sclHold, 1);
        repeat (40) @(negedge clk);
        check(sclHold == 1 && sclBus == 0, "R4 hold kept", sclHold, 1);
        check(rxData == 8'h11, "R4 no overrun", rxData, 8'h11);
        readData();
        check(rxFull == 0 && sclHold == 1, "R4 hold one more clock", sclHold, 1);
        @(negedge clk);
        check(sclHold == 0, "R4 release", sclHold, 0);
      end
    join
    check(rxData == 8'h96 && rxFull == 1, "R4 second byte", rxData, 8'h96);
    check(ack == 1, "R8 ack after stretch", ack, 1);
    readData();

    // R9: START/STOP mid-byte restarts the bit count
    clkBit(1'b1); clkBit(1'b0); clkBit(1'b1);
    pulseStartStop();
    sendByte(8'h6B, ack);
    check(rxData == 8'h6B, "R9 realign", rxData, 8'h6B);
    check(ack == 1 && rxFull == 1, "R9 ack after restart", ack, 1);

    // R9: START/STOP ends a stretch, held byte survives
    for (int i = 7; i >= 1; i--) clkBit(1'b0);
    repeat (5) @(negedge clk);
    check(sclHold == 1, "R9 stretch before restart", sclHold, 1);
    pulseStartStop();
    check(sclHold == 0 && sdaAck == 0, "R9 hold dropped", sclHold, 0);
    check(rxFull == 1 && rxData == 8'h6B, "R9 data kept", rxData, 8'h6B);
    readData();
    sendByte(8'h24, ack);
    check(rxData == 8'h24 && ack == 1, "R1 byte after restart", rxData, 8'h24);
    readData();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule